// File: doc/BRIEF.md
# Security-Banked Core Auxiliary Configuration Register

This block holds a 32-bit set of processor tuning controls. Software reaches it through a simple coprocessor-style port, and each request carries the requester's security state and privilege level. The stored bits drive a group of control outputs. These outputs can force individual clock enables to stay on, force the pipeline into single issue, turn prefetch hints and wait-for-interrupt into no-ops, and enable cache, parity and speculation features.

Write permission depends on the security state of the requester. A secure privileged request may change every implemented bit. A nonsecure privileged request can change only the L2 cache enable. That bit is held in two copies, one per security state, and every access uses the copy that matches the requester. Any user-mode request is refused: it raises a one-cycle undefined-instruction flag and returns no data. The L2 enable output shows the copy selected by the core's current security state.

Top module: `core_aux_cfg`

## Requirements
- R1: After reset, every control output is 0 and both L2 enable copies are 0. A privileged read in either security state then returns 0.
- R2: A user-mode request (reqPriv=0), read or write, secure or not, gives rspUndef=1 on the following cycle with rspRdata=0. It leaves every stored bit unchanged.
- R3: A secure privileged write updates bits 15..3 and bit 0 on the accepting clock edge. Each output follows its stored bit from then on: bit 15 forceTraceClk, 14 forceVecClk, 13 forceMainClk, 12 vecSingleIssue, 11 lsSingleIssue, 10 allSingleIssue, 9 prefetchNop, 8 wfiNop, 7 noBranchSizeMispred, 6 btbInvEnable, 5 vecL1Cache, 4 specAccessEn, 3 l1ParityEn, 0 aliasCheckDis.
- R4: A nonsecure privileged write leaves bits 15..3 and bit 0 unchanged.
- R5: Bit 1 is stored once per security state. A privileged write of bit 1 changes only the copy of the requester's state, and a privileged read returns that same copy in bit 1.
- R6: Bits 31..16 and bit 2 always read as 0. Writing 1s to them has no effect.
- R7: l2CacheEn equals the secure copy of bit 1 while coreSecure=1 and the nonsecure copy while coreSecure=0.
- R8: rspValid is 1 exactly in the cycle after a cycle with reqValid=1. rspUndef is 1 only in a cycle where rspValid is also 1.
- R9: A privileged read returns, in the next cycle, the register contents as they were before that clock edge, with the bit positions given in R3 and R5. Writes and idle cycles return rspRdata=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqSecure | input | 1 | Requester is in the secure state |
| reqPriv | input | 1 | Requester is privileged |
| reqWdata | input | 32 | Write data |
| coreSecure | input | 1 | Current security state of the core |
| rspValid | output | 1 | Response present |
| rspUndef | output | 1 | Undefined-instruction pulse |
| rspRdata | output | 32 | Read data |
| forceTraceClk | output | 1 | Keep the trace clock enabled |
| forceVecClk | output | 1 | Keep the vector-unit clock enabled |
| forceMainClk | output | 1 | Keep the main clock enabled |
| vecSingleIssue | output | 1 | Single-issue vector instructions |
| lsSingleIssue | output | 1 | Single-issue load/store instructions |
| allSingleIssue | output | 1 | Single-issue all instructions |
| prefetchNop | output | 1 | Treat prefetch hints as no-ops |
| wfiNop | output | 1 | Treat wait-for-interrupt as a no-op |
| noBranchSizeMispred | output | 1 | Suppress branch-size mispredicts |
| btbInvEnable | output | 1 | Carry out branch-target-buffer invalidates (0 = no-op) |
| vecL1Cache | output | 1 | Allow vector data in the L1 cache |
| specAccessEn | output | 1 | Allow speculative bus accesses |
| l1ParityEn | output | 1 | Enable L1 parity checking |
| l2CacheEn | output | 1 | L2 enable copy selected by coreSecure |
| aliasCheckDis | output | 1 | Disable L1 alias checking |

## Verification
The bench sends every combination of security state and privilege, for both reads and writes. This separates the trapping path, the nonsecure path that can reach only bit 1, and the secure path that writes everything. Write data uses all-ones, alternating and single-bit patterns, including 1s in the reserved positions, so that mask errors and swapped bit positions show up. The core security input changes independently of the requester's state, which shows whether the L2 output is selected by the core or by the request. Back-to-back write-then-read sequences check that read data reflects the contents from before each edge.

// File: rtl/core_aux_cfg_pkg.sv
package core_aux_cfg_pkg;
  localparam int unsigned REG_W = 32;
  localparam int unsigned L2_POS = 1;
  // bits a secure privileged write may change (bit 1 is banked separately)
  localparam logic [REG_W-1:0] SHARED_MASK = 32'h0000_FFF9;

  typedef struct packed {
    logic rdEn;      // legal read this cycle
    logic wrShared;  // secure write of shared bits
    logic wrL2Sec;   // write of secure L2 copy
    logic wrL2Ns;    // write of nonsecure L2 copy
    logic rdSecure;  // which L2 copy a read returns
  } acc_strobe_t;
endpackage

// File: rtl/core_aux_cfg_ctrl.sv
module core_aux_cfg_ctrl
  import core_aux_cfg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic        reqSecure,
  input  logic        reqPriv,
  output acc_strobe_t strobe,
  output logic        rspValid,
  output logic        rspUndef
);
  logic legal;

  always_comb begin
    legal           = reqValid && reqPriv;
    strobe.rdEn     = legal && !reqWrite;
    strobe.wrShared = legal && reqWrite && reqSecure;
    strobe.wrL2Sec  = legal && reqWrite && reqSecure;
    strobe.wrL2Ns   = legal && reqWrite && !reqSecure;
    strobe.rdSecure = reqSecure;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspUndef <= 1'b0;
    end else begin
      rspValid <= reqValid;
      rspUndef <= reqValid && !reqPriv;
    end
  end

  AST_UNDEF_WITH_RSP: assert property (@(posedge clk) disable iff (!rstN)
    rspUndef |-> rspValid); // R8
endmodule

// File: rtl/core_aux_cfg_dp.sv
module core_aux_cfg_dp
  import core_aux_cfg_pkg::*;
#(
  parameter logic [REG_W-1:0] WR_MASK = SHARED_MASK
) (
  input  logic             clk,
  input  logic             rstN,
  input  acc_strobe_t      strobe,
  input  logic [REG_W-1:0] wdata,
  input  logic             coreSecure,
  output logic [REG_W-1:0] ctlBits,
  output logic             l2Sel,
  output logic [REG_W-1:0] rdata
);
  logic l2Sec, l2Ns;
  logic [REG_W-1:0] readView;

  always_comb begin
    readView         = ctlBits & WR_MASK;
    readView[L2_POS] = strobe.rdSecure ? l2Sec : l2Ns;
    l2Sel            = coreSecure ? l2Sec : l2Ns;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlBits <= '0;
      l2Sec   <= 1'b0;
      l2Ns    <= 1'b0;
      rdata   <= '0;
    end else begin
      if (strobe.wrShared) ctlBits <= wdata & WR_MASK;
      if (strobe.wrL2Sec)  l2Sec   <= wdata[L2_POS];
      if (strobe.wrL2Ns)   l2Ns    <= wdata[L2_POS];
      rdata <= strobe.rdEn ? readView : '0;
    end
  end

  AST_NS_SPARES_SEC_L2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrL2Ns |=> $stable(l2Sec)); // R5
  AST_SEC_SPARES_NS_L2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrL2Sec |=> $stable(l2Ns)); // R5
endmodule

// File: rtl/core_aux_cfg.sv
module core_aux_cfg
  import core_aux_cfg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic        reqSecure,
  input  logic        reqPriv,
  input  logic [31:0] reqWdata,
  input  logic        coreSecure,
  output logic        rspValid,
  output logic        rspUndef,
  output logic [31:0] rspRdata,
  output logic        forceTraceClk,
  output logic        forceVecClk,
  output logic        forceMainClk,
  output logic        vecSingleIssue,
  output logic        lsSingleIssue,
  output logic        allSingleIssue,
  output logic        prefetchNop,
  output logic        wfiNop,
  output logic        noBranchSizeMispred,
  output logic        btbInvEnable,
  output logic        vecL1Cache,
  output logic        specAccessEn,
  output logic        l1ParityEn,
  output logic        l2CacheEn,
  output logic        aliasCheckDis
);
  acc_strobe_t      strobe;
  logic [REG_W-1:0] ctlBits;

  core_aux_cfg_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSecure(reqSecure), .reqPriv(reqPriv), .strobe(strobe),
    .rspValid(rspValid), .rspUndef(rspUndef)
  );

  core_aux_cfg_dp #(.WR_MASK(SHARED_MASK)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wdata(reqWdata),
    .coreSecure(coreSecure), .ctlBits(ctlBits), .l2Sel(l2CacheEn),
    .rdata(rspRdata)
  );

  assign forceTraceClk       = ctlBits[15];
  assign forceVecClk         = ctlBits[14];
  assign forceMainClk        = ctlBits[13];
  assign vecSingleIssue      = ctlBits[12];
  assign lsSingleIssue       = ctlBits[11];
  assign allSingleIssue      = ctlBits[10];
  assign prefetchNop         = ctlBits[9];
  assign wfiNop              = ctlBits[8];
  assign noBranchSizeMispred = ctlBits[7];
  assign btbInvEnable        = ctlBits[6];
  assign vecL1Cache          = ctlBits[5];
  assign specAccessEn        = ctlBits[4];
  assign l1ParityEn          = ctlBits[3];
  assign aliasCheckDis       = ctlBits[0];

  AST_USER_LEAVES_STATE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqPriv) |=> $stable(ctlBits)); // R2
  AST_UNDEF_NO_DATA: assert property (@(posedge clk) disable iff (!rstN)
    rspUndef |-> (rspRdata == '0)); // R2
  AST_NS_KEEPS_SHARED: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqPriv && reqWrite && !reqSecure) |=> $stable(ctlBits)); // R4
endmodule

// File: tb/tb_core_aux_cfg.sv
module tb_core_aux_cfg;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqSecure = 1'b0, reqPriv = 1'b0;
  logic [31:0] reqWdata = '0;
  logic coreSecure = 1'b0;
  logic rspValid, rspUndef;
  logic [31:0] rspRdata;
  logic forceTraceClk, forceVecClk, forceMainClk, vecSingleIssue, lsSingleIssue;
  logic allSingleIssue, prefetchNop, wfiNop, noBranchSizeMispred, btbInvEnable;
  logic vecL1Cache, specAccessEn, l1ParityEn, l2CacheEn, aliasCheckDis;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  // behavioural reference state
  int unsigned mCtl = 0;
  bit mL2s = 0, mL2n = 0;
  bit eRspValid = 0, eUndef = 0;
  int unsigned eRdata = 0;

  always #5 clk = ~clk;

  core_aux_cfg dut (.*);

  always @(posedge clk) begin
    if (!rstN) begin
      mCtl = 0; mL2s = 0; mL2n = 0;
      eRspValid = 0; eUndef = 0; eRdata = 0;
    end else begin
      eRspValid = reqValid;
      eUndef    = reqValid && !reqPriv;
      eRdata    = 0;
      if (reqValid && reqPriv && !reqWrite)
        eRdata = mCtl | ((reqSecure ? 32'(mL2s) : 32'(mL2n)) << 1);
      if (reqValid && reqPriv && reqWrite) begin
        if (reqSecure) begin
          mCtl = reqWdata & 32'h0000_FFF9;
          mL2s = reqWdata[1];
        end else begin
          mL2n = reqWdata[1];
        end
      end
    end
  end

  task automatic chk(string tag, int unsigned act, int unsigned exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int unsigned ctlView();
    return {16'h0, forceTraceClk, forceVecClk, forceMainClk, vecSingleIssue,
            lsSingleIssue, allSingleIssue, prefetchNop, wfiNop,
            noBranchSizeMispred, btbInvEnable, vecL1Cache, specAccessEn,
            l1ParityEn, 2'b00, aliasCheckDis};
  endfunction

  always @(negedge clk) begin
    if (rstN && !done) begin
      chk("R8 rspValid", 32'(rspValid), 32'(eRspValid));
      chk("R2 rspUndef", 32'(rspUndef), 32'(eUndef));
      chk("R9/R6 rspRdata", rspRdata, eRdata);
      chk("R3/R4 control outputs", ctlView(), mCtl);
      chk("R7 l2CacheEn", 32'(l2CacheEn), coreSecure ? 32'(mL2s) : 32'(mL2n));
    end
  end

  task automatic acc(bit wr, bit sec, bit priv, logic [31:0] d);
    @(negedge clk); #1;
    reqValid = 1'b1; reqWrite = wr; reqSecure = sec; reqPriv = priv; reqWdata = d;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      reqValid = 1'b0; reqWrite = 1'b0; reqWdata = '0;
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      nChecks++; nFails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #1; rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 outputs after reset", ctlView(), 0);
    chk("R1 l2 after reset", 32'(l2CacheEn), 0);
    acc(0, 1, 1, '0); acc(0, 0, 1, '0); idle(2);      // R1 reads return zero
    acc(1, 1, 1, 32'hFFFF_FFFF);                       // R3 R6 secure all ones
    acc(0, 1, 1, '0);                                  // expect FFFB
    acc(0, 0, 1, '0);                                  // R5 ns copy still 0
    acc(1, 0, 1, 32'h0000_0000);                       // R4 ns write zero
    acc(0, 1, 1, '0);
    acc(1, 0, 1, 32'hFFFF_FFFF);                       // R5 ns sets only bit1 copy
    idle(1); coreSecure = 1'b0; idle(1);
    coreSecure = 1'b1; idle(1);                        // R7
    acc(1, 1, 1, 32'h0000_0000);                       // secure clears its L2 copy
    coreSecure = 1'b0;
    acc(0, 0, 1, '0); acc(0, 1, 1, '0);
    acc(1, 1, 0, 32'hFFFF_FFFF);                       // R2 user secure write
    acc(1, 0, 0, 32'hFFFF_FFFF);                       // R2 user ns write
    acc(0, 1, 0, '0); acc(0, 0, 0, '0);                // R2 user reads
    idle(1);
    acc(1, 1, 1, 32'hA5A5_5A5A); acc(0, 1, 1, '0);     // R3 pattern
    acc(1, 1, 1, 32'h5A5A_A5A5); acc(0, 0, 1, '0);
    acc(1, 1, 1, 32'h0000_0004); acc(0, 1, 1, '0);     // R6 bit2 only
    acc(1, 1, 1, 32'h0000_0041); coreSecure = 1'b1;    // R3 btbInvEnable + alias
    acc(0, 1, 1, '0); idle(3);
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule